// File: doc/BRIEF.md
# Processor Operating Mode Sequencer

This block keeps track of the execution mode of a simple processor model. There are four modes: real address, protected, virtual-8086 and system management. The block takes the protection-enable and virtual-mode control bits, an interrupt-entry strobe, a management interrupt request and a resume strobe. From these it decides the current mode. It does not execute instructions and holds no register contents. Around each management episode it produces two one-cycle handshakes: a context-save pulse on entry and a context-restore pulse on resume.

A management interrupt can be taken from any of the three ordinary modes. The block remembers which mode was interrupted and returns to exactly that mode on resume. A request that arrives while management mode is already running is held and taken just after the resume. The block also supplies the handler fetch address, which is the management base plus a fixed handler offset. The base is reloaded on every resume with the value that the context logic reads back from the save area.

Top module: `opmode_seq`

## Requirements
- R1: While reset is held, and once it is released, the mode output reads real address mode. The mode encoding is 0 real, 1 protected, 2 virtual-8086, 3 management. The saved return mode also reads 0. Both pulses are low, the illegal-resume flag is low and the entry address is 0x38000 (base 0x30000 plus offset 0x8000).
- R2: In real mode, pe_bit=1 moves the mode to protected on the next clock edge. In protected mode, pe_bit=0 moves it back to real on the next edge.
- R3: In protected mode with pe_bit=1, vm_bit=1 enters virtual-8086 mode on the next edge. In virtual-8086 mode, either vm_bit=0 or an int_entry strobe returns the mode to protected on the next edge.
- R4: A management request taken in real, protected or virtual-8086 mode raises save_pulse for exactly one cycle, starting the cycle after the request. During that cycle the mode is unchanged. On the following cycle the mode reads management and ret_mode holds the interrupted mode. The request wins over any pe_bit or vm_bit change in the same cycle.
- R5: A resume strobe in management mode raises restore_pulse for exactly one cycle. On the cycle after the pulse the mode equals the saved return mode. In management mode, pe_bit and vm_bit have no effect.
- R6: At the end of the restore pulse the base register loads base_restore_val. The entry address then reads base_restore_val + 0x8000.
- R7: A management request seen while in management mode is held pending. One cycle after the mode returns from resume, save_pulse rises, and on the next cycle the mode is management again.
- R8: A resume strobe outside management mode produces no restore pulse and does not alter the mode. It sets the illegal-resume flag, which then stays set until reset.
- R9: Reset returns the block to the R1 state from any mode, management mode included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smi_req | input | 1 | Management interrupt request |
| rsm_strobe | input | 1 | Resume from management mode |
| pe_bit | input | 1 | Protection-enable control bit |
| vm_bit | input | 1 | Virtual-mode control bit |
| int_entry | input | 1 | Interrupt-entry strobe |
| base_restore_val | input | ADDR_W | Base value read back from the save area on resume |
| mode_o | output | 2 | Current mode (0 real, 1 protected, 2 virtual-8086, 3 management) |
| ret_mode_o | output | 2 | Mode to return to on resume |
| save_pulse_o | output | 1 | One-cycle context-save handshake |
| restore_pulse_o | output | 1 | One-cycle context-restore handshake |
| entry_addr_o | output | ADDR_W | Handler fetch address (base + 0x8000) |
| illegal_rsm_o | output | 1 | Sticky flag for a resume outside management mode |

## Verification
The hardest situation to reach from the ports is a pending request. A second request has to land inside an active management episode, and the block then has to re-enter straight after returning to the interrupted mode. The stimulus first enters management mode from virtual-8086 mode. It pulses the request again while in management mode and then issues a resume with a fresh base value. The bench then follows, cycle by cycle, the return to virtual-8086 mode, the automatic save pulse and the re-entry. A second directed case asserts reset in the middle of a management episode to show that the block comes back in real mode with the reset base.

// File: rtl/opmode_pkg.sv
package opmode_pkg;
  typedef enum logic [1:0] {
    MODE_REAL = 2'd0,
    MODE_PROT = 2'd1,
    MODE_V86  = 2'd2,
    MODE_SMM  = 2'd3
  } op_mode_t;

  typedef enum logic [1:0] {
    PH_RUN     = 2'd0,
    PH_SAVE    = 2'd1,
    PH_RESTORE = 2'd2
  } op_phase_t;
endpackage

// File: rtl/opmode_entry.sv
module opmode_entry #(
  parameter int               ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] BASE_RESET = 'h30000,
  parameter logic [ADDR_W-1:0] HANDLER_OFS = 'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_val,
  output logic [ADDR_W-1:0] entry_addr
);
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] base_d;

  always_comb begin
    base_d = base_q;
    if (load_en) base_d = load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= BASE_RESET;
    else        base_q <= base_d;
  end

  assign entry_addr = base_q + HANDLER_OFS;
endmodule

// File: rtl/opmode_fsm.sv
module opmode_fsm
  import opmode_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     smi_req,
  input  logic     rsm_strobe,
  input  logic     pe_bit,
  input  logic     vm_bit,
  input  logic     int_entry,
  output op_mode_t mode,
  output op_mode_t ret_mode,
  output logic     save_pulse,
  output logic     restore_pulse,
  output logic     illegal_rsm
);
  op_mode_t  mode_q, mode_d, ret_q, ret_d;
  op_phase_t ph_q, ph_d;
  logic      pend_q, pend_d;
  logic      ill_q, ill_d;

  always_comb begin
    mode_d = mode_q;
    ret_d  = ret_q;
    ph_d   = ph_q;
    pend_d = pend_q;
    ill_d  = ill_q;
    unique case (ph_q)
      PH_SAVE: begin
        mode_d = MODE_SMM;
        ph_d   = PH_RUN;
      end
      PH_RESTORE: begin
        mode_d = ret_q;
        ph_d   = PH_RUN;
        if (smi_req) pend_d = 1'b1;
      end
      default: begin
        if (mode_q == MODE_SMM) begin
          if (smi_req)    pend_d = 1'b1;
          if (rsm_strobe) ph_d   = PH_RESTORE;
        end else begin
          if (rsm_strobe) ill_d = 1'b1;
          if (smi_req || pend_q) begin
            ph_d   = PH_SAVE;
            ret_d  = mode_q;
            pend_d = 1'b0;
          end else begin
            unique case (mode_q)
              MODE_REAL: if (pe_bit) mode_d = MODE_PROT;
              MODE_PROT: begin
                if (!pe_bit)     mode_d = MODE_REAL;
                else if (vm_bit) mode_d = MODE_V86;
              end
              MODE_V86: if (!vm_bit || int_entry) mode_d = MODE_PROT;
              default: mode_d = mode_q;
            endcase
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_REAL;
      ret_q  <= MODE_REAL;
      ph_q   <= PH_RUN;
      pend_q <= 1'b0;
      ill_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      ret_q  <= ret_d;
      ph_q   <= ph_d;
      pend_q <= pend_d;
      ill_q  <= ill_d;
    end
  end

  assign mode          = mode_q;
  assign ret_mode      = ret_q;
  assign save_pulse    = (ph_q == PH_SAVE);
  assign restore_pulse = (ph_q == PH_RESTORE);
  assign illegal_rsm   = ill_q;
endmodule

// File: rtl/opmode_seq.sv
module opmode_seq
  import opmode_pkg::*;
#(
  parameter int               ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] BASE_RESET = 'h30000,
  parameter logic [ADDR_W-1:0] HANDLER_OFS = 'h8000,
  parameter int               SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smi_req,
  input  logic              rsm_strobe,
  input  logic              pe_bit,
  input  logic              vm_bit,
  input  logic              int_entry,
  input  logic [ADDR_W-1:0] base_restore_val,
  output logic [1:0]        mode_o,
  output logic [1:0]        ret_mode_o,
  output logic              save_pulse_o,
  output logic              restore_pulse_o,
  output logic [ADDR_W-1:0] entry_addr_o,
  output logic              illegal_rsm_o
);
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;
  op_mode_t               mode_w, ret_w;
  logic                   restore_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  opmode_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .smi_req       (smi_req),
    .rsm_strobe    (rsm_strobe),
    .pe_bit        (pe_bit),
    .vm_bit        (vm_bit),
    .int_entry     (int_entry),
    .mode          (mode_w),
    .ret_mode      (ret_w),
    .save_pulse    (save_pulse_o),
    .restore_pulse (restore_w),
    .illegal_rsm   (illegal_rsm_o)
  );

  opmode_entry #(
    .ADDR_W      (ADDR_W),
    .BASE_RESET  (BASE_RESET),
    .HANDLER_OFS (HANDLER_OFS)
  ) u_entry (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load_en    (restore_w),
    .load_val   (base_restore_val),
    .entry_addr (entry_addr_o)
  );

  assign mode_o          = mode_w;
  assign ret_mode_o      = ret_w;
  assign restore_pulse_o = restore_w;
endmodule

// File: rtl/opmode_seq_chk.sv
module opmode_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rsm_strobe,
  input logic [1:0]        mode_o,
  input logic [1:0]        ret_mode_o,
  input logic              save_pulse_o,
  input logic              restore_pulse_o,
  input logic              illegal_rsm_o,
  input logic [ADDR_W-1:0] entry_addr_o
);
  AST_SAVE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    save_pulse_o |=> !save_pulse_o); // R4
  AST_SAVE_THEN_MGMT: assert property (@(posedge clk) disable iff (!rst_n)
    save_pulse_o |=> (mode_o == 2'd3)); // R4
  AST_MGMT_ONLY_VIA_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!save_pulse_o && mode_o != 2'd3) |=> (mode_o != 2'd3)); // R4
  AST_RESTORE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    restore_pulse_o |=> !restore_pulse_o); // R5
  AST_RESTORE_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    restore_pulse_o |=> (mode_o == $past(ret_mode_o))); // R5
  AST_REAL_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0 && !save_pulse_o) |=> (mode_o == 2'd0 || mode_o == 2'd1)); // R2
  AST_BAD_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    (rsm_strobe && mode_o != 2'd3) |=> (illegal_rsm_o && !restore_pulse_o)); // R8
  AST_ILLEGAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_rsm_o |=> illegal_rsm_o); // R8
  AST_ADDR_HOLD_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (!restore_pulse_o && $past(rst_n)) |=> $stable(entry_addr_o)); // R6
endmodule

bind opmode_seq opmode_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .rsm_strobe      (rsm_strobe),
  .mode_o          (mode_o),
  .ret_mode_o      (ret_mode_o),
  .save_pulse_o    (save_pulse_o),
  .restore_pulse_o (restore_pulse_o),
  .illegal_rsm_o   (illegal_rsm_o),
  .entry_addr_o    (entry_addr_o)
);

// File: tb/opmode_seq_tb.sv
module opmode_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          smi_req, rsm_strobe, pe_bit, vm_bit, int_entry;
  logic [AW-1:0] base_restore_val;
  logic [1:0]    mode_o, ret_mode_o;
  logic          save_pulse_o, restore_pulse_o, illegal_rsm_o;
  logic [AW-1:0] entry_addr_o;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opmode_seq u_dut (
    .clk              (clk),
    .rst_n            (rst_n),
    .smi_req          (smi_req),
    .rsm_strobe       (rsm_strobe),
    .pe_bit           (pe_bit),
    .vm_bit           (vm_bit),
    .int_entry        (int_entry),
    .base_restore_val (base_restore_val),
    .mode_o           (mode_o),
    .ret_mode_o       (ret_mode_o),
    .save_pulse_o     (save_pulse_o),
    .restore_pulse_o  (restore_pulse_o),
    .entry_addr_o     (entry_addr_o),
    .illegal_rsm_o    (illegal_rsm_o)
  );

  task automatic tick();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; smi_req = 0; rsm_strobe = 0; pe_bit = 0; vm_bit = 0;
    int_entry = 0; base_restore_val = '0;
    tick(); tick();
    rst_n = 1'b1;
    tick(); tick(); tick();
  endtask

  task automatic smi_enter(input logic [1:0] from);
    smi_req = 1'b1; tick();
    smi_req = 1'b0;
    check("R4", "save pulse", save_pulse_o, 1);
    check("R4", "mode during save", mode_o, from);
    tick();
    check("R4", "save width", save_pulse_o, 0);
    check("R4", "mode after save", mode_o, 3);
    check("R4", "ret mode", ret_mode_o, from);
  endtask

  task automatic resume(input logic [31:0] val, input logic [1:0] back);
    base_restore_val = val;
    rsm_strobe = 1'b1; tick();
    rsm_strobe = 1'b0;
    check("R5", "restore pulse", restore_pulse_o, 1);
    check("R5", "mode during restore", mode_o, 3);
    tick();
    check("R5", "restore width", restore_pulse_o, 0);
    check("R5", "mode after resume", mode_o, back);
    check("R6", "entry addr", entry_addr_o, val + 32'h8000);
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0; smi_req = 0; rsm_strobe = 0; pe_bit = 0; vm_bit = 0;
    int_entry = 0; base_restore_val = '0;
    tick();
    check("R1", "mode in reset", mode_o, 0);
    rst_n = 1'b1;
    tick(); tick(); tick();
    check("R1", "mode", mode_o, 0);
    check("R1", "ret mode", ret_mode_o, 0);
    check("R1", "pulses", {save_pulse_o, restore_pulse_o}, 0);
    check("R1", "illegal flag", illegal_rsm_o, 0);
    check("R1", "entry addr", entry_addr_o, 32'h38000);
  endtask

  task automatic t_mode_walk();
    pe_bit = 1; tick();
    check("R2", "real->prot", mode_o, 1);
    vm_bit = 1; tick();
    check("R3", "prot->v86", mode_o, 2);
    int_entry = 1; tick();
    int_entry = 0;
    check("R3", "v86 int->prot", mode_o, 1);
    tick();
    check("R3", "prot->v86 again", mode_o, 2);
    vm_bit = 0; tick();
    check("R3", "v86 vm clear->prot", mode_o, 1);
    pe_bit = 0; tick();
    check("R2", "prot->real", mode_o, 0);
  endtask

  task automatic t_smi_each_mode();
    smi_enter(2'd0);
    pe_bit = 1; vm_bit = 1; tick();
    check("R5", "pe/vm ignored in mgmt", mode_o, 3);
    pe_bit = 0; vm_bit = 0;
    resume(32'h30000, 2'd0);
    pe_bit = 1; tick();
    smi_req = 1; vm_bit = 1; tick();
    smi_req = 0;
    check("R4", "smi beats vm", mode_o, 1);
    check("R4", "save pulse prot", save_pulse_o, 1);
    tick();
    check("R4", "ret prot", ret_mode_o, 1);
    resume(32'h000A0000, 2'd1);
    tick();
    check("R3", "prot->v86 after resume", mode_o, 2);
    smi_enter(2'd2);
    resume(32'h00050000, 2'd2);
  endtask

  task automatic t_pending();
    smi_enter(2'd2);
    smi_req = 1; tick();
    smi_req = 0;
    check("R7", "no save while in mgmt", save_pulse_o, 0);
    resume(32'h00070000, 2'd2);
    tick();
    check("R7", "pending save pulse", save_pulse_o, 1);
    check("R7", "mode during pending save", mode_o, 2);
    tick();
    check("R7", "pending re-entry", mode_o, 3);
    check("R7", "pending ret", ret_mode_o, 2);
    resume(32'h00030000, 2'd2);
    tick();
    check("R7", "pending cleared", save_pulse_o, 0);
  endtask

  task automatic t_illegal();
    check("R8", "flag clear before", illegal_rsm_o, 0);
    rsm_strobe = 1; tick();
    rsm_strobe = 0;
    check("R8", "no restore pulse", restore_pulse_o, 0);
    check("R8", "mode unchanged", mode_o, 2);
    check("R8", "flag set", illegal_rsm_o, 1);
    tick(); tick();
    check("R8", "flag sticky", illegal_rsm_o, 1);
  endtask

  task automatic t_reset_from_mgmt();
    smi_enter(2'd2);
    rst_n = 1'b0; #1;
    check("R9", "mode in reset from mgmt", mode_o, 0);
    check("R9", "illegal cleared", illegal_rsm_o, 0);
    check("R9", "base reset", entry_addr_o, 32'h38000);
    pe_bit = 0; vm_bit = 0;
    tick();
    rst_n = 1'b1;
    tick(); tick(); tick();
    check("R9", "mode after release", mode_o, 0);
    check("R9", "ret after release", ret_mode_o, 0);
  endtask

  initial begin
    t_reset_state();
    t_mode_walk();
    t_smi_each_mode();
    t_pending();
    t_illegal();
    t_reset_from_mgmt();
    do_reset();
    check("R1", "mode after final reset", mode_o, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule